// File: doc/BRIEF.md
# Burst Flash Read Sequencer

This block is the device-side read engine of a 16-bit NOR-style memory with burst reads. A 16-bit configuration word sets the read mode, the wait before the first word, the level and lead of the ready flag, and how the burst address advances. In synchronous mode, a pulse on `addr_vld` captures a start address. The block waits the programmed number of clocks and then returns one word per clock from a small internal synchronous RAM. The address runs straight on, or it circles inside an aligned window of 8 or 16 words.

The settings are captured at each address latch. A configuration write made during a burst therefore changes nothing until the next latch. A new `addr_vld` pulse drops the running burst and starts a new one. In asynchronous mode, which is the state after reset, a latch starts no burst. The RAM write port accepts a word in any mode.

Top module: `burst_read_seq`

## Requirements
- R1: After reset, `data_vld` is 0 and `rdy` is 0. The reset configuration is asynchronous mode, latency 13 clocks, `rdy` active high and coincident with data, and straight (non-wrapping) addressing.
- R2: When the captured mode is asynchronous, an `addr_vld` pulse starts no burst and `data_vld` stays 0. Such a latch also ends a running burst. `mem_we` writes `mem_wdata` to `mem_waddr` at the next edge whatever the mode.
- R3: Configuration bits: bit 15 is the mode (0 synchronous, 1 asynchronous); bits 14:11 are the latency code, MSB first; bit 10 is the ready level; bit 8 is the ready lead; bits 2:0 are the burst code. Bits 9 and 7:3 have no effect.
- R4: Latency code n (1 to 12) gives L = n+2 clocks. The first word is presented for the L-th rising edge after the edge that latched the address, and `data_vld` is 0 before that.
- R5: A write whose latency code is 0000, 1101, 1110 or 1111 keeps the previous latency. The other fields of that write still take effect.
- R6: From the first word on, one word is presented per clock. With burst code 000 the word address rises by 1 each clock, modulo the array size, and `rdata` is the array word at that address.
- R7: With burst code 010 the low 3 address bits count up modulo 8. With code 011 the low 4 address bits count up modulo 16. In both cases the upper bits hold the latched value.
- R8: A write whose burst code is anything other than 000, 010 or 011 keeps the previous burst setting.
- R9: When bit 10 is 1, `rdy` is high when active and low when idle. When bit 10 is 0, the levels are reversed.
- R10: When bit 8 is 1, `rdy` is active exactly in the clocks where `data_vld` is 1. When bit 8 is 0, `rdy` becomes active one clock before the first word and stays active while data flows.
- R11: An `addr_vld` pulse during a burst, whether in the wait or while data flows, ends that burst. It restarts the latency count from the new address.
- R12: A configuration write takes effect only at the next address latch. A write in the same cycle as a latch, or in the middle of a burst, does not alter the running burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 16 | Configuration word |
| mem_we | input | 1 | RAM write strobe |
| mem_waddr | input | AW (8) | RAM write address |
| mem_wdata | input | DW (16) | RAM write data |
| addr_vld | input | 1 | Address-latch strobe |
| addr_in | input | AW (8) | Burst start address |
| rdata | output | DW (16) | Read word |
| data_vld | output | 1 | `rdata` holds a burst word |
| rdy | output | 1 | Ready flag, level and lead set by configuration |

## Verification
Count the edge that captures `addr_vld` as edge 0. The state after edge m is observed at the falling edge that follows it. `data_vld` and the selected `rdata` word are due from observation L-1 onward, so a consumer sees them at edge L. `rdy` is due at L-1, or at L-2 when it leads. The bench turns each latch into a per-observation list of expected `data_vld`, `rdy` and word values, using the configuration captured at that latch. A monitor pops one entry at every falling edge. An abort shortens the list so that the next latch takes over in the same cycle as the design does.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

  localparam int CFG_W    = 16;
  localparam int LAT_W    = 5;
  localparam int MODE_BIT = 15;
  localparam int LAT_MSB  = 14;
  localparam int LAT_LSB  = 11;
  localparam int POL_BIT  = 10;
  localparam int LEAD_BIT = 8;
  localparam int BL_MSB   = 2;

  typedef enum logic [1:0] {
    BL_LINEAR = 2'd0,
    BL_WRAP8  = 2'd1,
    BL_WRAP16 = 2'd2
  } blen_e;

  typedef struct packed {
    logic       async_rd;
    logic [3:0] lat_code;
    logic       rdy_hi;
    logic       rdy_with;
    blen_e      blen;
  } cfg_t;

  localparam cfg_t CFG_RESET = '{async_rd: 1'b1, lat_code: 4'd11,
                                 rdy_hi: 1'b1, rdy_with: 1'b1,
                                 blen: BL_LINEAR};

  // usable latency codes give 3..14 clocks
  function automatic logic lat_code_ok(input logic [3:0] c);
    return (c >= 4'd1) && (c <= 4'd12);
  endfunction

  function automatic logic [LAT_W-1:0] lat_cycles(input logic [3:0] c);
    return {1'b0, c} + LAT_W'(2);
  endfunction

  // fold a written word into the held settings, dropping reserved codes
  function automatic cfg_t cfg_merge(input cfg_t prev, input logic [CFG_W-1:0] w);
    cfg_t n;
    n          = prev;
    n.async_rd = w[MODE_BIT];
    n.rdy_hi   = w[POL_BIT];
    n.rdy_with = w[LEAD_BIT];
    if (lat_code_ok(w[LAT_MSB:LAT_LSB])) n.lat_code = w[LAT_MSB:LAT_LSB];
    case (w[BL_MSB:0])
      3'b000:  n.blen = BL_LINEAR;
      3'b010:  n.blen = BL_WRAP8;
      3'b011:  n.blen = BL_WRAP16;
      default: n.blen = prev.blen;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/bs_cfg_reg.sv
module bs_cfg_reg
  import burst_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [CFG_W-1:0] wdata,
  output cfg_t             cfg_q
);

  always_ff @(posedge clk) begin
    if (!rst_n)  cfg_q <= CFG_RESET;
    else if (we) cfg_q <= cfg_merge(cfg_q, wdata);
  end

endmodule

// File: rtl/bs_addr_seq.sv
module bs_addr_seq
  import burst_seq_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          latch,
  input  logic [AW-1:0] addr_in,
  input  cfg_t          cfg_q,
  output cfg_t          act,
  output logic          busy,
  output logic          cnt_zero,
  output logic          cnt_le1,
  output logic [AW-1:0] word_addr,
  output logic [AW-1:0] rd_addr
);

  localparam logic [AW-1:0] MASK8  = AW'(7);
  localparam logic [AW-1:0] MASK16 = AW'(15);

  // address of word i of a burst from base b under window mode m
  function automatic logic [AW-1:0] word_at(input logic [AW-1:0] b,
                                            input logic [AW-1:0] i,
                                            input blen_e m);
    logic [AW-1:0] s;
    logic [AW-1:0] mk;
    s = b + i;
    case (m)
      BL_WRAP8:  mk = MASK8;
      BL_WRAP16: mk = MASK16;
      default:   mk = '1;
    endcase
    return (b & ~mk) | (s & mk);
  endfunction

  cfg_t             act_n;
  logic             busy_n;
  logic [LAT_W-1:0] cnt, cnt_n;
  logic [AW-1:0]    base, base_n;
  logic [AW-1:0]    idx, idx_n;

  always_comb begin
    act_n  = act;
    busy_n = busy;
    cnt_n  = cnt;
    base_n = base;
    idx_n  = idx;
    if (latch) begin
      act_n  = cfg_q;
      busy_n = !cfg_q.async_rd;
      cnt_n  = lat_cycles(cfg_q.lat_code) - LAT_W'(1);
      base_n = addr_in;
      idx_n  = '0;
    end else if (busy) begin
      if (cnt != '0) cnt_n = cnt - LAT_W'(1);
      else           idx_n = idx + AW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act  <= CFG_RESET;
      busy <= 1'b0;
      cnt  <= '0;
      base <= '0;
      idx  <= '0;
    end else begin
      act  <= act_n;
      busy <= busy_n;
      cnt  <= cnt_n;
      base <= base_n;
      idx  <= idx_n;
    end
  end

  assign cnt_zero  = (cnt == '0);
  assign cnt_le1   = (cnt <= LAT_W'(1));
  assign word_addr = word_at(base, idx, act.blen);
  assign rd_addr   = word_at(base_n, idx_n, act_n.blen);

endmodule

// File: rtl/bs_word_ram.sv
module bs_word_ram #(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata_q
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata_q <= mem[raddr];
  end

endmodule

// File: rtl/bs_rdy_gen.sv
module bs_rdy_gen (
  input  logic busy,
  input  logic cnt_zero,
  input  logic cnt_le1,
  input  logic rdy_hi,
  input  logic rdy_with,
  output logic rdy_active,
  output logic rdy
);

  always_comb begin
    rdy_active = busy && (rdy_with ? cnt_zero : cnt_le1);
    rdy        = rdy_hi ? rdy_active : !rdy_active;
  end

endmodule

// File: rtl/burst_read_seq.sv
module burst_read_seq
  import burst_seq_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [15:0]   cfg_wdata,
  input  logic          mem_we,
  input  logic [AW-1:0] mem_waddr,
  input  logic [DW-1:0] mem_wdata,
  input  logic          addr_vld,
  input  logic [AW-1:0] addr_in,
  output logic [DW-1:0] rdata,
  output logic          data_vld,
  output logic          rdy
);

  cfg_t          cfg_q;
  cfg_t          act;
  logic          busy;
  logic          cnt_zero;
  logic          cnt_le1;
  logic [AW-1:0] word_addr;
  logic [AW-1:0] rd_addr;
  logic          rdy_active;

  // named events for the checker
  logic          act_async;
  logic          act_rdy_hi;
  logic          act_rdy_with;
  logic [1:0]    act_blen;

  bs_cfg_reg u_cfg (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (cfg_we),
    .wdata (cfg_wdata),
    .cfg_q (cfg_q)
  );

  bs_addr_seq #(.AW(AW)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .latch     (addr_vld),
    .addr_in   (addr_in),
    .cfg_q     (cfg_q),
    .act       (act),
    .busy      (busy),
    .cnt_zero  (cnt_zero),
    .cnt_le1   (cnt_le1),
    .word_addr (word_addr),
    .rd_addr   (rd_addr)
  );

  bs_word_ram #(.AW(AW), .DW(DW)) u_ram (
    .clk     (clk),
    .we      (mem_we),
    .waddr   (mem_waddr),
    .wdata   (mem_wdata),
    .raddr   (rd_addr),
    .rdata_q (rdata)
  );

  bs_rdy_gen u_rdy (
    .busy       (busy),
    .cnt_zero   (cnt_zero),
    .cnt_le1    (cnt_le1),
    .rdy_hi     (act.rdy_hi),
    .rdy_with   (act.rdy_with),
    .rdy_active (rdy_active),
    .rdy        (rdy)
  );

  assign data_vld     = busy && cnt_zero;
  assign act_async    = act.async_rd;
  assign act_rdy_hi   = act.rdy_hi;
  assign act_rdy_with = act.rdy_with;
  assign act_blen     = act.blen;

endmodule

// File: rtl/bs_checker.sv
module bs_checker #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          addr_vld,
  input logic          data_vld,
  input logic          rdy,
  input logic          act_async,
  input logic          act_rdy_hi,
  input logic          act_rdy_with,
  input logic [1:0]    act_blen,
  input logic [AW-1:0] word_addr
);

  logic rdy_on;
  assign rdy_on = (rdy == act_rdy_hi);

  assert_no_data_after_latch_R4: assert property (@(posedge clk) disable iff (!rst_n)
    addr_vld |=> !data_vld);

  assert_burst_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (data_vld && !addr_vld) |=> data_vld);

  assert_async_silent_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (act_async && !addr_vld) |=> !data_vld);

  assert_linear_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (data_vld && $past(data_vld) && !$past(addr_vld) && act_blen == 2'd0)
      |-> (word_addr == AW'($past(word_addr) + AW'(1))));

  assert_wrap8_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (data_vld && $past(data_vld) && !$past(addr_vld) && act_blen == 2'd1)
      |-> ((word_addr[AW-1:3] == $past(word_addr[AW-1:3])) &&
           (word_addr[2:0] == 3'($past(word_addr[2:0]) + 3'd1))));

  assert_wrap16_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (data_vld && $past(data_vld) && !$past(addr_vld) && act_blen == 2'd2)
      |-> ((word_addr[AW-1:4] == $past(word_addr[AW-1:4])) &&
           (word_addr[3:0] == 4'($past(word_addr[3:0]) + 4'd1))));

  assert_rdy_with_data_R10: assert property (@(posedge clk) disable iff (!rst_n)
    act_rdy_with |-> (rdy_on == data_vld));

  assert_rdy_lead_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!act_rdy_with && rdy_on && !data_vld && !addr_vld) |=> data_vld);

  assert_rdy_covers_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
    data_vld |-> rdy_on);

endmodule

bind burst_read_seq bs_checker #(.AW(AW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .addr_vld     (addr_vld),
  .data_vld     (data_vld),
  .rdy          (rdy),
  .act_async    (act_async),
  .act_rdy_hi   (act_rdy_hi),
  .act_rdy_with (act_rdy_with),
  .act_blen     (act_blen),
  .word_addr    (word_addr)
);

// File: tb/sim_burst_read_seq.sv
`timescale 1ns/1ps
module sim_burst_read_seq;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [15:0] cfg_wdata;
  logic        mem_we;
  logic [7:0]  mem_waddr;
  logic [15:0] mem_wdata;
  logic        addr_vld;
  logic [7:0]  addr_in;
  logic [15:0] rdata;
  logic        data_vld;
  logic        rdy;

  always #2.5 clk = ~clk;

  burst_read_seq #(.AW(8), .DW(16)) u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_wdata (cfg_wdata),
    .mem_we    (mem_we),
    .mem_waddr (mem_waddr),
    .mem_wdata (mem_wdata),
    .addr_vld  (addr_vld),
    .addr_in   (addr_in),
    .rdata     (rdata),
    .data_vld  (data_vld),
    .rdy       (rdy)
  );

  typedef struct {
    bit          dv;
    bit          rd;
    logic [15:0] data;
    string       tag;
  } exp_t;

  exp_t        sb[$];
  int          checks = 0;
  int          errors = 0;
  logic [15:0] mem_m [256];

  // bench view of the configuration
  bit m_async = 1'b1;
  int m_lat   = 13;
  bit m_pol   = 1'b1;
  bit m_with  = 1'b1;
  int m_win   = 0;

  function automatic void model_cfg(input logic [15:0] v);
    int code;
    code = int'(v[14:11]);
    if (code > 0 && code < 13) m_lat = code + 2;
    if (v[2:0] == 3'd0) m_win = 0;
    else if (v[2:0] == 3'd2) m_win = 8;
    else if (v[2:0] == 3'd3) m_win = 16;
    m_async = v[15];
    m_pol   = v[10];
    m_with  = v[8];
  endfunction

  function automatic logic [7:0] exp_addr(input logic [7:0] a, input int i);
    int s;
    s = int'(a) + i;
    if (m_win == 0) return 8'(s);
    return 8'((int'(a) & ~(m_win - 1)) | (s & (m_win - 1)));
  endfunction

  task automatic check1(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: one expected item per falling edge
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      checks++;
      if (data_vld !== e.dv || rdy !== e.rd || (e.dv && rdata !== e.data)) begin
        errors++;
        $display("FAIL %s actual dv=%0b rdy=%0b data=%h expected dv=%0b rdy=%0b data=%h",
                 e.tag, data_vld, rdy, rdata, e.dv, e.rd, e.data);
      end
    end
  end

  task automatic cfg_write(input logic [15:0] v);
    @(negedge clk);
    cfg_we    = 1'b1;
    cfg_wdata = v;
    @(negedge clk);
    cfg_we    = 1'b0;
    model_cfg(v);
  endtask

  task automatic mem_write(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    mem_we    = 1'b1;
    mem_waddr = a;
    mem_wdata = d;
    @(negedge clk);
    mem_we    = 1'b0;
    mem_m[a]  = d;
  endtask

  // driver: latch an address, push expectations for ncyc observations
  task automatic burst(input logic [7:0] a, input int ncyc, input string tag,
                       input bit do_cfg, input int cfg_at, input logic [15:0] cv);
    @(negedge clk);
    addr_in  = a;
    addr_vld = 1'b1;
    if (do_cfg && cfg_at == 0) begin
      cfg_we    = 1'b1;
      cfg_wdata = cv;
    end
    @(posedge clk);
    for (int m = 0; m < ncyc; m++) begin
      exp_t e;
      bit   act;
      e.dv   = !m_async && (m >= m_lat - 1);
      act    = !m_async && (m_with ? (m >= m_lat - 1) : (m >= m_lat - 2));
      e.rd   = m_pol ? act : !act;
      e.data = e.dv ? mem_m[exp_addr(a, m - (m_lat - 1))] : 16'h0;
      e.tag  = tag;
      sb.push_back(e);
    end
    for (int m = 0; m < ncyc; m++) begin
      @(negedge clk);
      addr_vld  = 1'b0;
      cfg_we    = do_cfg && (cfg_at == m + 1);
      cfg_wdata = cv;
    end
    if (do_cfg) model_cfg(cv);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n     = 1'b0;
    cfg_we    = 1'b0;
    cfg_wdata = 16'h0;
    mem_we    = 1'b0;
    mem_waddr = 8'h0;
    mem_wdata = 16'h0;
    addr_vld  = 1'b0;
    addr_in   = 8'h0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check1(data_vld === 1'b0, "R1 data_vld after reset", int'(data_vld), 0);
    check1(rdy === 1'b0, "R1 rdy after reset", int'(rdy), 0);

    // fill the array in asynchronous mode (R2)
    for (int i = 0; i < 256; i++) mem_write(8'(i), 16'(i * 257) ^ 16'h5A3C);

    burst(8'h10, 20, "R2 async latch", 1'b0, 0, 16'h0);

    // reserved latency and burst codes keep reset values (R1, R5, R8)
    cfg_write(16'h0501);
    burst(8'h10, 20, "R1 R5 R8 default latency 13", 1'b0, 0, 16'h0);

    // shortest latency, spare bits set, linear across top of array (R3, R6)
    cfg_write(16'h0FF8);
    burst(8'hFC, 10, "R3 R6 linear wrap of array", 1'b0, 0, 16'h0);

    // 8-word window (R7)
    cfg_write(16'h2502);
    burst(8'h2D, 20, "R7 wrap8", 1'b0, 0, 16'h0);

    // 16-word window, longest latency 14 (R4, R7)
    cfg_write(16'h6503);
    burst(8'h47, 35, "R4 R7 wrap16 latency 14", 1'b0, 0, 16'h0);

    // code 1101 and burst 111 reserved; low-active ready leading data (R5, R8, R9)
    cfg_write(16'h6807);
    burst(8'h33, 30, "R9 R5 R8 active-low lead", 1'b0, 0, 16'h0);

    // high-active ready one clock ahead, latency 4 (R10)
    cfg_write(16'h1400);
    burst(8'h80, 10, "R10 lead", 1'b0, 0, 16'h0);

    // aborts in the wait and while data flows (R11)
    burst(8'h90, 3, "R11 abort in wait", 1'b0, 0, 16'h0);
    burst(8'hA0, 12, "R11 restart", 1'b0, 0, 16'h0);
    burst(8'hB0, 7, "R11 abort in data", 1'b0, 0, 16'h0);
    burst(8'hC0, 8, "R11 restart", 1'b0, 0, 16'h0);

    // settings move only at the next latch (R12)
    burst(8'h20, 10, "R12 same-cycle write", 1'b1, 0, 16'h0D02);
    burst(8'h20, 12, "R12 new settings", 1'b0, 0, 16'h0);
    burst(8'h40, 15, "R12 mid-burst write", 1'b1, 5, 16'h1400);
    burst(8'h40, 8, "R12 after mid write", 1'b0, 0, 16'h0);

    // array write in synchronous mode (R2)
    mem_write(8'h41, 16'hBEEF);
    burst(8'h40, 8, "R2 write in sync mode", 1'b0, 0, 16'h0);

    // back to asynchronous: latch ends the running burst (R2)
    cfg_write(16'h8D00);
    burst(8'h50, 12, "R2 async stop", 1'b0, 0, 16'h0);

    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule